// File: doc/BRIEF.md
# Three-Wire Control Register File

This block receives 16-bit command words on a slow three-wire port (serial data, shift clock, latch strobe) and turns them into the static settings of a stereo audio converter. All three wires are synchronized into the system clock. Each word carries a 2-bit address that selects one of four registers. Two registers hold per-channel attenuation, one holds the channel settings and one holds the format and rate settings. Every field appears on its own output.

An attenuation word updates the channel's level only when its load flag is set. A word with the flag clear is accepted but leaves the level unchanged, so a controller can stage a value and commit it with a later write. A coupling bit in the format register makes the left level drive both channels. The right channel's own level is kept and comes back when coupling is cleared. A frame that does not hold exactly 16 shift-clock edges before the strobe is dropped.

Top module: `ctl3w_regfile`

## Requirements
- R1: After reset the outputs are: both attenuation levels 8'hFF (0 dB), mute 0, de-emphasis 0, halt 0 (conversion enabled), word length 2'b00 (16-bit), routing 4'b1001 (stereo), I2S select 0 (normal format), word-clock swap 0 (left on high), coupling 0 (per channel), rate multiple 2'b00, rate group 2'b00, zero-detect enable 0.
- R2: A word is shifted in most significant bit (bit 15) first, one bit per rising shift-clock edge. It is applied on the rising edge of the strobe that follows the 16th bit. Bits 10:9 select the register: 0 left level, 1 right level, 2 channel settings, 3 format settings.
- R3: Register 0 holds the left level in bits 7:0 and the load flag in bit 8. The left level output takes bits 7:0 only when bit 8 is 1. When bit 8 is 0 the output keeps its previous value.
- R4: Register 1 behaves as register 0 for the right channel: bits 7:0 are the level and bit 8 is the load flag.
- R5: Register 2: bit 0 mute, bit 1 de-emphasis, bit 2 halt, bits 4:3 word length, bits 8:5 output routing.
- R6: Register 3: bit 0 I2S select, bit 1 word-clock swap, bit 2 attenuation coupling, bits 5:4 rate multiple, bits 7:6 rate group, bit 8 zero-detect enable.
- R7: While coupling is 1, the right level output equals the left level output. When coupling returns to 0, the right output again shows the last right level that was loaded.
- R8: A frame with fewer or more than 16 shift-clock edges before the strobe changes no output.
- R9: Bits 15:11 of a word have no effect on any output.
- R10: The falling edge of the strobe discards any partial frame, so a complete word sent after a short, dropped frame is applied correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cw_sdata | input | 1 | Serial command data, asynchronous |
| cw_sclk | input | 1 | Serial shift clock, asynchronous |
| cw_strobe | input | 1 | Latch strobe, asynchronous |
| att_left_o | output | 8 | Left attenuation level in effect |
| att_right_o | output | 8 | Right attenuation level in effect (after coupling) |
| mute_o | output | 1 | Soft mute request |
| deemph_o | output | 1 | De-emphasis enable |
| halt_o | output | 1 | Force output to bipolar zero |
| wlen_o | output | 2 | Input word length code |
| route_o | output | 4 | Output routing code |
| fmt_i2s_o | output | 1 | I2S input format select |
| lr_swap_o | output | 1 | Word-clock polarity swap |
| att_couple_o | output | 1 | Left level drives both channels |
| rate_mult_o | output | 2 | Sampling-rate multiple code |
| rate_group_o | output | 2 | Sampling-rate group code |
| zdet_en_o | output | 1 | Zero-detect enable |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 16-bit word, the address at bit 9 and 8-bit levels. This setting places all five reserved bits above the address, and they fall off the end of the shift register, so the random words with random reserved bits exercise R9 in every frame. The saturating counter is exercised with 15- and 17-edge frames on either side of the 16-bit boundary. The two-stage synchronizer sets the strobe-to-output latency that the bench waits out before it samples.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

   localparam int FIELD_W = 9;

   typedef enum logic [1:0] {
      RA_ATT_L = 2'd0,
      RA_ATT_R = 2'd1,
      RA_CHAN  = 2'd2,
      RA_FMT   = 2'd3
   } reg_addr_t;

   typedef struct packed {
      logic [3:0] route;
      logic [1:0] wlen;
      logic       halt;
      logic       deemph;
      logic       mute;
   } chan_cfg_t;

   typedef struct packed {
      logic       zdet;
      logic [1:0] rgroup;
      logic [1:0] rmult;
      logic       couple;
      logic       lr_swap;
      logic       i2s;
   } fmt_cfg_t;

   localparam chan_cfg_t CHAN_RST = '{route: 4'b1001, wlen: 2'b00,
                                      halt: 1'b0, deemph: 1'b0, mute: 1'b0};
   localparam fmt_cfg_t  FMT_RST  = '{zdet: 1'b0, rgroup: 2'b00, rmult: 2'b00,
                                      couple: 1'b0, lr_swap: 1'b0, i2s: 1'b0};

   function automatic chan_cfg_t dec_chan(input logic [FIELD_W-1:0] f);
      chan_cfg_t c;
      c.mute   = f[0];
      c.deemph = f[1];
      c.halt   = f[2];
      c.wlen   = f[4:3];
      c.route  = f[8:5];
      return c;
   endfunction

   function automatic fmt_cfg_t dec_fmt(input logic [FIELD_W-1:0] f);
      fmt_cfg_t c;
      c.i2s     = f[0];
      c.lr_swap = f[1];
      c.couple  = f[2];
      c.rmult   = f[5:4];
      c.rgroup  = f[7:6];
      c.zdet    = f[8];
      return c;
   endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stage_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ctl3w_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= '0;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift #(
   parameter int WORD_W = 16,
   parameter int KEEP_W = 11,
   localparam int SAT   = WORD_W + 1,
   localparam int CNT_W = $clog2(SAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              latch_s,
   output logic [KEEP_W-1:0] word_o,
   output logic              wr_stb_o
);
   logic              sclk_d, latch_d;
   logic              sclk_rise, latch_rise, latch_fall;
   logic [CNT_W-1:0]  cnt_q;
   logic [KEEP_W-1:0] sr_q;

   generate
      if (KEEP_W > WORD_W) begin : g_bad_keep
         $error("ctl3w_shift: KEEP_W exceeds WORD_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         latch_d <= 1'b0;
      end else begin
         sclk_d  <= sclk_s;
         latch_d <= latch_s;
      end
   end

   assign sclk_rise  = sclk_s & ~sclk_d;
   assign latch_rise = latch_s & ~latch_d;
   assign latch_fall = ~latch_s & latch_d;

   // Bits above KEEP_W leave the top of the register and are never decoded.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (latch_fall) begin
         sr_q  <= '0;
         cnt_q <= '0;
      end else if (sclk_rise && !latch_s) begin
         sr_q <= {sr_q[KEEP_W-2:0], sdat_s};
         if (cnt_q != CNT_W'(SAT)) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign wr_stb_o = latch_rise && (cnt_q == CNT_W'(WORD_W));
   assign word_o   = sr_q;

   // R10: a falling strobe leaves an empty frame
   a_r10_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(latch_s) |=> (cnt_q == '0));

   // R2: each accepted shift edge advances the count by one until saturation
   a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && !latch_s && !latch_fall && cnt_q < CNT_W'(SAT))
      |=> (cnt_q == $past(cnt_q) + 1'b1));

   // R8: the count never runs past the saturation value
   a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(SAT));
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
   import ctl3w_pkg::*;
#(
   parameter int              KEEP_W   = 11,
   parameter int              ADDR_LSB = 9,
   parameter int              ATT_W    = 8,
   parameter logic [ATT_W-1:0] ATT_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [KEEP_W-1:0] word,
   output logic [ATT_W-1:0]  att_l_o,
   output logic [ATT_W-1:0]  att_r_o,
   output chan_cfg_t         chan_o,
   output fmt_cfg_t          fmt_o
);
   localparam int N_CH = 2;

   reg_addr_t          addr;
   logic               ld;
   logic [ATT_W-1:0]   att_q [N_CH];
   chan_cfg_t          chan_q;
   fmt_cfg_t           fmt_q;

   generate
      if (KEEP_W != ADDR_LSB + 2) begin : g_bad_keep
         $error("ctl3w_regs: KEEP_W must be ADDR_LSB + 2");
      end
      if (ADDR_LSB < FIELD_W || ATT_W + 1 > ADDR_LSB) begin : g_bad_layout
         $error("ctl3w_regs: field layout overlaps the address");
      end
   endgenerate

   assign addr = reg_addr_t'(word[ADDR_LSB +: 2]);
   assign ld   = word[ATT_W];

   generate
      for (genvar c = 0; c < N_CH; c++) begin : g_att
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               att_q[c] <= ATT_RST;
            else if (wr_stb && addr == reg_addr_t'(c) && ld)
               att_q[c] <= word[ATT_W-1:0];
         end

         // R3 (channel 0) and R4 (channel 1): level held without a loading write
         a_r3_att_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_stb && addr == reg_addr_t'(c) && ld) |=> $stable(att_q[c]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q <= CHAN_RST;
         fmt_q  <= FMT_RST;
      end else if (wr_stb) begin
         if (addr == RA_CHAN) chan_q <= dec_chan(word[FIELD_W-1:0]);
         if (addr == RA_FMT)  fmt_q  <= dec_fmt(word[FIELD_W-1:0]);
      end
   end

   assign att_l_o = att_q[0];
   assign att_r_o = att_q[1];
   assign chan_o  = chan_q;
   assign fmt_o   = fmt_q;

   // R5: channel settings only move on a write to register 2
   a_r5_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && addr == RA_CHAN) |=> $stable(chan_q));

   // R6: format settings only move on a write to register 3
   a_r6_fmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && addr == RA_FMT) |=> $stable(fmt_q));
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
   import ctl3w_pkg::*;
#(
   parameter int              SYNC_STAGES = 2,
   parameter int              WORD_W      = 16,
   parameter int              ADDR_LSB    = 9,
   parameter int              ATT_W       = 8,
   parameter logic [ATT_W-1:0] ATT_RST    = '1,
   localparam int             KEEP_W      = ADDR_LSB + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cw_sdata,
   input  logic             cw_sclk,
   input  logic             cw_strobe,
   output logic [ATT_W-1:0] att_left_o,
   output logic [ATT_W-1:0] att_right_o,
   output logic             mute_o,
   output logic             deemph_o,
   output logic             halt_o,
   output logic [1:0]       wlen_o,
   output logic [3:0]       route_o,
   output logic             fmt_i2s_o,
   output logic             lr_swap_o,
   output logic             att_couple_o,
   output logic [1:0]       rate_mult_o,
   output logic [1:0]       rate_group_o,
   output logic             zdet_en_o
);
   logic [2:0]        pins_s;
   logic [KEEP_W-1:0] word;
   logic              wr_stb;
   logic [ATT_W-1:0]  att_l, att_r;
   chan_cfg_t         chan;
   fmt_cfg_t          fmt;

   generate
      if (KEEP_W > WORD_W) begin : g_bad_word
         $error("ctl3w_regfile: address does not fit in the word");
      end
   endgenerate

   ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({cw_sclk, cw_sdata, cw_strobe}),
      .q_o   (pins_s)
   );

   ctl3w_shift #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) i_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_s   (pins_s[2]),
      .sdat_s   (pins_s[1]),
      .latch_s  (pins_s[0]),
      .word_o   (word),
      .wr_stb_o (wr_stb)
   );

   ctl3w_regs #(.KEEP_W(KEEP_W), .ADDR_LSB(ADDR_LSB), .ATT_W(ATT_W),
                .ATT_RST(ATT_RST)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .word    (word),
      .att_l_o (att_l),
      .att_r_o (att_r),
      .chan_o  (chan),
      .fmt_o   (fmt)
   );

   assign att_left_o   = att_l;
   assign att_right_o  = fmt.couple ? att_l : att_r;
   assign mute_o       = chan.mute;
   assign deemph_o     = chan.deemph;
   assign halt_o       = chan.halt;
   assign wlen_o       = chan.wlen;
   assign route_o      = chan.route;
   assign fmt_i2s_o    = fmt.i2s;
   assign lr_swap_o    = fmt.lr_swap;
   assign att_couple_o = fmt.couple;
   assign rate_mult_o  = fmt.rmult;
   assign rate_group_o = fmt.rgroup;
   assign zdet_en_o    = fmt.zdet;

   // R7: coupled channels show one level
   a_r7_coupled_equal: assert property (@(posedge clk) disable iff (!rst_n)
      att_couple_o |-> (att_right_o == att_left_o));

   // R8: no setting moves without a strobe edge seen by the shifter
   a_r8_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (chan != $past(chan) || fmt != $past(fmt)) |-> $past(wr_stb));
endmodule

// File: tb/test_ctl3w_regfile.sv
module test_ctl3w_regfile;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cw_sdata = 1'b0, cw_sclk = 1'b0, cw_strobe = 1'b0;
   logic [7:0] att_left_o, att_right_o;
   logic mute_o, deemph_o, halt_o, fmt_i2s_o, lr_swap_o, att_couple_o, zdet_en_o;
   logic [1:0] wlen_o, rate_mult_o, rate_group_o;
   logic [3:0] route_o;

   int checks = 0, errors = 0;

   // bench model
   logic [7:0] m_al, m_ar;
   logic m_mute, m_deemph, m_halt, m_i2s, m_swap, m_couple, m_zdet;
   logic [1:0] m_wlen, m_rmult, m_rgroup;
   logic [3:0] m_route;

   always #4 clk = ~clk;

   ctl3w_regfile i_ctl3w_regfile (
      .clk(clk), .rst_n(rst_n), .cw_sdata(cw_sdata), .cw_sclk(cw_sclk),
      .cw_strobe(cw_strobe), .att_left_o(att_left_o), .att_right_o(att_right_o),
      .mute_o(mute_o), .deemph_o(deemph_o), .halt_o(halt_o), .wlen_o(wlen_o),
      .route_o(route_o), .fmt_i2s_o(fmt_i2s_o), .lr_swap_o(lr_swap_o),
      .att_couple_o(att_couple_o), .rate_mult_o(rate_mult_o),
      .rate_group_o(rate_group_o), .zdet_en_o(zdet_en_o));

   task automatic model_reset();
      m_al = 8'hFF; m_ar = 8'hFF;
      m_mute = 0; m_deemph = 0; m_halt = 0; m_wlen = 2'b00; m_route = 4'b1001;
      m_i2s = 0; m_swap = 0; m_couple = 0; m_rmult = 0; m_rgroup = 0; m_zdet = 0;
   endtask

   task automatic model_apply(input logic [15:0] w);
      case (w[10:9])
         2'd0: if (w[8]) m_al = w[7:0];
         2'd1: if (w[8]) m_ar = w[7:0];
         2'd2: begin
            m_mute = w[0]; m_deemph = w[1]; m_halt = w[2];
            m_wlen = w[4:3]; m_route = w[8:5];
         end
         default: begin
            m_i2s = w[0]; m_swap = w[1]; m_couple = w[2];
            m_rmult = w[5:4]; m_rgroup = w[7:6]; m_zdet = w[8];
         end
      endcase
   endtask

   function automatic logic [32:0] exp_vec();
      return {m_al, (m_couple ? m_al : m_ar), m_mute, m_deemph, m_halt, m_wlen,
              m_route, m_i2s, m_swap, m_couple, m_rmult, m_rgroup, m_zdet};
   endfunction

   function automatic logic [32:0] act_vec();
      return {att_left_o, att_right_o, mute_o, deemph_o, halt_o, wlen_o,
              route_o, fmt_i2s_o, lr_swap_o, att_couple_o, rate_mult_o,
              rate_group_o, zdet_en_o};
   endfunction

   task automatic check(input string req);
      checks++;
      if (act_vec() !== exp_vec()) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act_vec(), exp_vec());
      end
   endtask

   task automatic send_frame(input logic [16:0] w, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         cw_sdata = w[i];
         repeat (3) @(negedge clk);
         cw_sclk = 1'b1;
         repeat (4) @(negedge clk);
         cw_sclk = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (3) @(negedge clk);
      cw_strobe = 1'b1;
      repeat (8) @(negedge clk);
      cw_strobe = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic write_word(input logic [15:0] w, input string req);
      send_frame({1'b0, w}, 16);
      model_apply(w);
      check(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] w;
      void'($urandom(32'h5EED_0C3A));
      model_reset();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset defaults");

      // R3: staged value not applied, then loaded
      write_word(16'h0040, "R3 flag clear keeps left level");
      write_word(16'h0140, "R3 flag set loads left level");
      // R4: same for right
      write_word(16'h0233, "R4 flag clear keeps right level");
      write_word(16'h0333, "R4 flag set loads right level");
      // R5 / R6 directed layouts
      write_word(16'h0415, "R5 channel fields");
      write_word(16'h0755, "R6 format fields");
      // R7 coupling on and off
      write_word(16'h0604, "R7 coupling mirrors left");
      write_word(16'h0600, "R7 right level restored");
      // R9 reserved bits set
      write_word(16'hF95A, "R9 reserved bits ignored");
      // R8 wrong counts
      send_frame({1'b0, 16'h05E7}, 15);
      check("R8 fifteen edges dropped");
      send_frame({1'b1, 16'h05E7}, 17);
      check("R8 seventeen edges dropped");
      // R10 partial frame cleared by strobe, then full word
      send_frame(17'h00015, 5);
      check("R10 partial frame dropped");
      write_word(16'h0566, "R10 word after partial frame");

      // R2: random words across all registers with random reserved bits
      for (int k = 0; k < 48; k++) begin
         w = 16'($urandom);
         write_word(w, "R2 random word");
      end

      // R2 boundary: all-ones and all-zero words on the last register
      write_word(16'hFFFF, "R2 all ones format word");
      write_word(16'h0600, "R2 format cleared");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule